// File: doc/BRIEF.md
# Power-of-Two Block Allocator

This block hands out regions of a fixed pool in power-of-two sizes. The pool is split into minimum-size units; with the default parameters there are 16 units of 64 KB each, which gives five size orders from one unit (64 KB) to the whole pool (1024 KB). An allocation asks for a size in units. The size is rounded up to the next power of two. The block then returns the unit offset of a granted region, or a failure flag. A release gives only the unit offset. The block looks up the size it granted at that offset, returns the region and joins it with its partner region as far as it can.

A free bit for every block of every order is held in registers and is visible on an output port. When no block of the wanted order is free, a larger free block is halved once per clock until a block of the wanted order exists. On a release, the partner is the block at offset XOR size. While the partner is free, the two are joined into one block of the next order, one order per clock. Requests use a valid/ready handshake. Each request ends with a single-cycle done pulse that carries the result.

Top module: `buddy_alloc`

## Requirements
- R1: An allocation of `req_size` units is served at order k, the smallest k with 2^k >= `req_size`. A size of 0 is treated as 1 unit.
- R2: An allocation takes a block from the smallest order at or above the needed order that has a free block. Within that order it takes the lowest address. The reported `resp_offset` is the block's start in units.
- R3: If the chosen block is larger than needed, it is halved one clock at a time. The lower half is kept for further splitting or for the grant, and the upper half becomes free at the next lower order.
- R4: Bit `k*16+i` of `free_bits` is 1 when the block of 2^k units at unit offset `i*2^k` is free. After reset only bit 64 (the whole pool) is set, `req_ready` is 1 and `resp_done` is 0.
- R5: A release frees the block at its granted order and then joins it with its partner at offset XOR size. This repeats at each larger order while the partner is free, with one join per clock.
- R6: Joining stops at a partner that is not free or when the whole pool has been rebuilt. When the whole pool is free, no other free bit is set.
- R7: A release at an offset where no block starts (never granted, already freed, or inside a granted block) sets `resp_err` and leaves `free_bits` unchanged.
- R8: An allocation larger than the pool, or one for which no large enough free block exists, sets `resp_fail` and leaves `free_bits` unchanged.
- R9: `req_ready` goes low on the clock after a request is accepted and stays low until the cycle in which `resp_done` pulses. `resp_done` is high for one cycle per request.
- R10: Allocating 1, 2, 1, 2 units gives offsets 0, 2, 1, 4. Releasing them in the order third, first, second, fourth then rebuilds the whole pool, with the expected free layout after every step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and takes a request |
| req_free | input | 1 | 0: allocate, 1: release |
| req_size | input | SZ_W (6) | Allocation size in minimum units |
| req_offset | input | NUM_ORDERS-1 (4) | Release offset in minimum units |
| resp_done | output | 1 | One-cycle pulse when a request ends |
| resp_fail | output | 1 | Allocation could not be served |
| resp_err | output | 1 | Release at an offset with no granted block |
| resp_offset | output | NUM_ORDERS-1 (4) | Granted block start in units |
| free_bits | output | NUM_ORDERS*2^(NUM_ORDERS-1) (80) | Free bit per block per order |

## Verification
The bench uses the default parameters: five orders, 16 units and a 6-bit size field. With these, a single allocation can need four splits in a row and a single release can need four joins. A request of 17 units goes beyond the pool. The bench walks a table that starts with the allocate-and-release sequence of R10. It then fills the pool completely, releases at bad offsets, and mixes block sizes so that both partner-busy stops and full rebuilds occur. Every step is checked against the expected free layout and offset.

// File: rtl/buddy_pkg.sv
package buddy_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SPLIT,
    ST_MERGE
  } buddy_state_e;

  // Smallest order whose block covers the unit count; 0 counts as 1.
  function automatic int order_for_units(input int units, input int limit);
    int r;
    r = limit;
    for (int o = limit - 1; o >= 0; o--) begin
      if ((1 << o) >= units) r = o;
    end
    return r;
  endfunction

endpackage

// File: rtl/buddy_lowest.sv
module buddy_lowest #(
  parameter int N = 16,
  parameter int W = 4
) (
  input  logic [N-1:0] vec,
  output logic         found,
  output logic [W-1:0] idx
);
  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = W'(i);
    end
  end
endmodule

// File: rtl/buddy_scan.sv
module buddy_scan #(
  parameter int NUM_ORDERS = 5,
  parameter int NUNITS     = 16,
  parameter int OFF_W      = 4,
  parameter int ORD_W      = 3
) (
  input  logic [NUM_ORDERS-1:0][NUNITS-1:0] free_map,
  input  logic [ORD_W-1:0]                  min_ord,
  output logic                              hit,
  output logic [ORD_W-1:0]                  hit_ord,
  output logic [OFF_W-1:0]                  hit_idx
);
  logic [NUM_ORDERS-1:0]            lvl_found;
  logic [NUM_ORDERS-1:0][OFF_W-1:0] lvl_idx;

  for (genvar k = 0; k < NUM_ORDERS; k++) begin : g_ord
    buddy_lowest #(.N(NUNITS), .W(OFF_W)) u_low (
      .vec   (free_map[k]),
      .found (lvl_found[k]),
      .idx   (lvl_idx[k])
    );
  end

  // Smallest qualifying order wins: walk downward so it is written last.
  always_comb begin
    hit     = 1'b0;
    hit_ord = '0;
    hit_idx = '0;
    for (int k = NUM_ORDERS - 1; k >= 0; k--) begin
      if (k >= int'(min_ord) && lvl_found[k]) begin
        hit     = 1'b1;
        hit_ord = ORD_W'(k);
        hit_idx = lvl_idx[k];
      end
    end
  end
endmodule

// File: rtl/buddy_alloc.sv
module buddy_alloc
  import buddy_pkg::*;
#(
  parameter int NUM_ORDERS = 5,
  parameter int SZ_W       = NUM_ORDERS + 1
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        req_valid,
  output logic                                        req_ready,
  input  logic                                        req_free,
  input  logic [SZ_W-1:0]                             req_size,
  input  logic [NUM_ORDERS-2:0]                       req_offset,
  output logic                                        resp_done,
  output logic                                        resp_fail,
  output logic                                        resp_err,
  output logic [NUM_ORDERS-2:0]                       resp_offset,
  output logic [NUM_ORDERS*(1<<(NUM_ORDERS-1))-1:0]   free_bits
);
  localparam int NUNITS = 1 << (NUM_ORDERS - 1);
  localparam int OFF_W  = NUM_ORDERS - 1;
  localparam int ORD_W  = $clog2(NUM_ORDERS + 1);
  localparam int TOP    = NUM_ORDERS - 1;

  function automatic logic [OFF_W-1:0] child_idx(input logic [OFF_W-1:0] idx, input logic hi);
    return OFF_W'({idx, hi});
  endfunction

  function automatic logic [OFF_W-1:0] block_base(input logic [OFF_W-1:0] idx, input logic [ORD_W-1:0] ord);
    return OFF_W'(idx << ord);
  endfunction

  logic [NUM_ORDERS-1:0][NUNITS-1:0] free_map;
  logic [NUNITS-1:0][ORD_W-1:0]      own_q;     // granted order + 1 at block start, 0 = none
  buddy_state_e                      state;
  logic [ORD_W-1:0]                  tgt_ord, cur_ord;
  logic [OFF_W-1:0]                  cur_idx;
  logic                              op_free_q;

  logic                              scan_hit;
  logic [ORD_W-1:0]                  scan_ord;
  logic [OFF_W-1:0]                  scan_idx;

  buddy_scan #(.NUM_ORDERS(NUM_ORDERS), .NUNITS(NUNITS), .OFF_W(OFF_W), .ORD_W(ORD_W)) u_scan (
    .free_map (free_map),
    .min_ord  (tgt_ord),
    .hit      (scan_hit),
    .hit_ord  (scan_ord),
    .hit_idx  (scan_idx)
  );

  // Named events for the assertions
  logic             accept, too_big, split_ev, grant_ev, nospace_ev, merge_ev, settle_ev;
  int               req_ord_i;
  logic [ORD_W-1:0] own_at_req;
  logic [OFF_W-1:0] bud_idx;

  assign req_ready  = (state == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign req_ord_i  = order_for_units(int'(req_size), SZ_W);
  assign too_big    = req_ord_i >= NUM_ORDERS;
  assign own_at_req = own_q[req_offset];
  assign grant_ev   = (state == ST_SPLIT) && scan_hit && (scan_ord == tgt_ord);
  assign split_ev   = (state == ST_SPLIT) && scan_hit && (scan_ord != tgt_ord);
  assign nospace_ev = (state == ST_SPLIT) && !scan_hit;
  assign bud_idx    = cur_idx ^ OFF_W'(1);
  assign merge_ev   = (state == ST_MERGE) && (cur_ord != ORD_W'(TOP)) && free_map[cur_ord][bud_idx];
  assign settle_ev  = (state == ST_MERGE) && !merge_ev;
  assign free_bits  = free_map;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state            <= ST_IDLE;
      free_map         <= '0;
      free_map[TOP][0] <= 1'b1;
      own_q            <= '0;
      tgt_ord          <= '0;
      cur_ord          <= '0;
      cur_idx          <= '0;
      op_free_q        <= 1'b0;
      resp_done        <= 1'b0;
      resp_fail        <= 1'b0;
      resp_err         <= 1'b0;
      resp_offset      <= '0;
    end else begin
      resp_done <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          op_free_q <= req_free;
          if (!req_free) begin
            if (too_big) begin
              resp_done <= 1'b1;
              resp_fail <= 1'b1;
              resp_err  <= 1'b0;
            end else begin
              tgt_ord <= ORD_W'(req_ord_i);
              state   <= ST_SPLIT;
            end
          end else if (own_at_req == '0) begin
            resp_done <= 1'b1;
            resp_fail <= 1'b0;
            resp_err  <= 1'b1;
          end else begin
            own_q[req_offset] <= '0;
            cur_ord           <= own_at_req - 1'b1;
            cur_idx           <= req_offset >> (own_at_req - 1'b1);
            state             <= ST_MERGE;
          end
        end
        ST_SPLIT: begin
          if (nospace_ev) begin
            resp_done <= 1'b1;
            resp_fail <= 1'b1;
            resp_err  <= 1'b0;
            state     <= ST_IDLE;
          end else if (grant_ev) begin
            free_map[scan_ord][scan_idx]                  <= 1'b0;
            own_q[block_base(scan_idx, scan_ord)]         <= scan_ord + 1'b1;
            resp_offset                                   <= block_base(scan_idx, scan_ord);
            resp_done                                     <= 1'b1;
            resp_fail                                     <= 1'b0;
            resp_err                                      <= 1'b0;
            state                                         <= ST_IDLE;
          end else begin
            free_map[scan_ord][scan_idx]                         <= 1'b0;
            free_map[scan_ord - 1'b1][child_idx(scan_idx, 1'b0)] <= 1'b1;
            free_map[scan_ord - 1'b1][child_idx(scan_idx, 1'b1)] <= 1'b1;
          end
        end
        ST_MERGE: begin
          if (merge_ev) begin
            free_map[cur_ord][bud_idx] <= 1'b0;
            cur_ord                    <= cur_ord + 1'b1;
            cur_idx                    <= cur_idx >> 1;
          end else begin
            free_map[cur_ord][cur_idx] <= 1'b1;
            resp_done                  <= 1'b1;
            resp_fail                  <= 1'b0;
            resp_err                   <= 1'b0;
            state                      <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!req_ready || resp_done)); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_done |-> req_ready); // R9
  AST_SPLIT_FEEDS: assert property (@(posedge clk) disable iff (!rst_n)
    split_ev |=> scan_hit); // R3
  AST_MERGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    merge_ev |=> (cur_ord == $past(cur_ord) + 1'b1)); // R5
  AST_SETTLE_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
    settle_ev |=> req_ready); // R6
  AST_POOL_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
    free_map[TOP][0] |-> ($countones(free_map) == 1)); // R6
  AST_ERR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_done && resp_err) |-> $stable(free_map)); // R7
  AST_FAIL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_done && resp_fail) |-> $stable(free_map)); // R8
  AST_GRANT_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_done && !op_free_q && !resp_fail) |-> (own_q[resp_offset] != '0)); // R2
endmodule

// File: tb/buddy_alloc_bench.sv
module buddy_alloc_bench;
  localparam int MW = 80;

  typedef struct packed {
    logic          op;    // 0 allocate, 1 release
    logic [5:0]    arg;   // size or offset in units
    logic          fail;
    logic          err;
    logic [3:0]    off;
    logic [MW-1:0] map;
  } vec_t;

  function automatic logic [MW-1:0] fm(input int a, input int b, input int c, input int d);
    logic [MW-1:0] m;
    m = '0;
    if (a >= 0) m[a] = 1'b1;
    if (b >= 0) m[b] = 1'b1;
    if (c >= 0) m[c] = 1'b1;
    if (d >= 0) m[d] = 1'b1;
    return m;
  endfunction

  localparam int NV = 27;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 6'd1,  1'b0, 1'b0, 4'd0, fm(1, 17, 33, 49)},   // R10 R3 A
    '{1'b0, 6'd2,  1'b0, 1'b0, 4'd2, fm(1, 33, 49, -1)},   // R10 B
    '{1'b0, 6'd1,  1'b0, 1'b0, 4'd1, fm(33, 49, -1, -1)},  // R10 C
    '{1'b0, 6'd2,  1'b0, 1'b0, 4'd4, fm(19, 49, -1, -1)},  // R10 D
    '{1'b1, 6'd1,  1'b0, 1'b0, 4'd0, fm(1, 19, 49, -1)},   // R10 free C
    '{1'b1, 6'd0,  1'b0, 1'b0, 4'd0, fm(16, 19, 49, -1)},  // R10 free A
    '{1'b1, 6'd2,  1'b0, 1'b0, 4'd0, fm(32, 19, 49, -1)},  // R10 free B
    '{1'b1, 6'd4,  1'b0, 1'b0, 4'd0, fm(64, -1, -1, -1)},  // R10 R6 free D
    '{1'b1, 6'd0,  1'b0, 1'b1, 4'd0, fm(64, -1, -1, -1)},  // R7 double release
    '{1'b0, 6'd17, 1'b1, 1'b0, 4'd0, fm(64, -1, -1, -1)},  // R8 too large
    '{1'b0, 6'd16, 1'b0, 1'b0, 4'd0, fm(-1, -1, -1, -1)},  // R1 whole pool
    '{1'b0, 6'd1,  1'b1, 1'b0, 4'd0, fm(-1, -1, -1, -1)},  // R8 no space
    '{1'b1, 6'd3,  1'b0, 1'b1, 4'd0, fm(-1, -1, -1, -1)},  // R7 inside a block
    '{1'b1, 6'd0,  1'b0, 1'b0, 4'd0, fm(64, -1, -1, -1)},  // R6 top order
    '{1'b0, 6'd3,  1'b0, 1'b0, 4'd0, fm(33, 49, -1, -1)},  // R1 3 -> 4 units
    '{1'b0, 6'd0,  1'b0, 1'b0, 4'd4, fm(5, 19, 49, -1)},   // R1 R3 size 0
    '{1'b1, 6'd5,  1'b0, 1'b1, 4'd0, fm(5, 19, 49, -1)},   // R7 free half
    '{1'b1, 6'd4,  1'b0, 1'b0, 4'd0, fm(33, 49, -1, -1)},  // R5 two joins
    '{1'b1, 6'd0,  1'b0, 1'b0, 4'd0, fm(64, -1, -1, -1)},  // R6
    '{1'b0, 6'd2,  1'b0, 1'b0, 4'd0, fm(17, 33, 49, -1)},  // R2
    '{1'b0, 6'd2,  1'b0, 1'b0, 4'd2, fm(33, 49, -1, -1)},  // R2
    '{1'b1, 6'd0,  1'b0, 1'b0, 4'd0, fm(16, 33, 49, -1)},  // R5 partner busy
    '{1'b0, 6'd2,  1'b0, 1'b0, 4'd0, fm(33, 49, -1, -1)},  // R2 smallest order first
    '{1'b0, 6'd4,  1'b0, 1'b0, 4'd4, fm(49, -1, -1, -1)},  // R2
    '{1'b1, 6'd0,  1'b0, 1'b0, 4'd0, fm(16, 49, -1, -1)},  // R5
    '{1'b1, 6'd2,  1'b0, 1'b0, 4'd0, fm(32, 49, -1, -1)},  // R5
    '{1'b1, 6'd4,  1'b0, 1'b0, 4'd0, fm(64, -1, -1, -1)}   // R6
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_free = 1'b0;
  logic [5:0]    req_size = '0;
  logic [3:0]    req_offset = '0;
  logic          req_ready, resp_done, resp_fail, resp_err;
  logic [3:0]    resp_offset;
  logic [MW-1:0] free_bits;
  int            checks = 0;
  int            errors = 0;
  int            cyc = 0;

  always #4 clk = ~clk;

  buddy_alloc u_buddy_alloc (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_free(req_free), .req_size(req_size), .req_offset(req_offset),
    .resp_done(resp_done), .resp_fail(resp_fail), .resp_err(resp_err),
    .resp_offset(resp_offset), .free_bits(free_bits)
  );

  task automatic check(input bit ok, input string req, input logic [MW-1:0] act, input logic [MW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input int n);
    int guard;
    @(negedge clk);
    req_valid  = 1'b1;
    req_free   = v.op;
    req_size   = v.arg;
    req_offset = v.arg[3:0];
    @(negedge clk);
    req_valid = 1'b0;
    if (!resp_done) check(req_ready == 1'b0, "R9 busy after accept", MW'(req_ready), '0);
    guard = 0;
    while (!resp_done && guard < 64) begin
      @(negedge clk);
      guard++;
    end
    check(resp_done == 1'b1, $sformatf("R9 done vec %0d", n), MW'(resp_done), MW'(1));
    check(resp_fail == v.fail, $sformatf("R8 fail vec %0d", n), MW'(resp_fail), MW'(v.fail));
    check(resp_err == v.err, $sformatf("R7 err vec %0d", n), MW'(resp_err), MW'(v.err));
    if (!v.op && !v.fail)
      check(resp_offset == v.off, $sformatf("R2 offset vec %0d", n), MW'(resp_offset), MW'(v.off));
    check(free_bits == v.map, $sformatf("R4 layout vec %0d", n), free_bits, v.map);
    @(negedge clk);
    check(resp_done == 1'b0, $sformatf("R9 pulse vec %0d", n), MW'(resp_done), '0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R4 reset state
    check(free_bits == fm(64, -1, -1, -1), "R4 reset layout", free_bits, fm(64, -1, -1, -1));
    check(req_ready == 1'b1, "R4 reset ready", MW'(req_ready), MW'(1));
    check(resp_done == 1'b0, "R4 reset done", MW'(resp_done), '0);

    for (int i = 0; i < NV; i++) run_vec(TBL[i], i);

    // R4 reset in the middle of a split chain
    @(negedge clk);
    req_valid = 1'b1; req_free = 1'b0; req_size = 6'd1; req_offset = '0;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(free_bits == fm(64, -1, -1, -1), "R4 layout after mid reset", free_bits, fm(64, -1, -1, -1));
    check(req_ready == 1'b1, "R4 ready after mid reset", MW'(req_ready), MW'(1));
    // R1 R3 allocation works again after reset
    run_vec('{1'b0, 6'd1, 1'b0, 1'b0, 4'd0, fm(1, 17, 33, 49)}, 100);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule